// File: doc/BRIEF.md
# Synchronous Link Port Shifter

This block is a full-duplex byte shifter for a two-wire synchronous link that has no start or stop bits. One register does both jobs. Its most significant bit leaves on the serial output while the bit arriving on the serial input enters at the least significant end. After one byte time the register holds the byte that came in, and the byte that was written has gone out.

Software writes the outgoing byte into the data register. It then writes the control register with the start bit set, and the clock-source bit picks the role. In master role the block makes its own shift clock with a programmable divider. By default this is 8192 Hz from a 4.194304 MHz system clock. The block drives that clock onto the clock pin, which rests high and pulses low once per bit. In slave role the block follows an external clock pin, which it passes through a synchronizer. It then waits for as long as it takes for eight clock periods to arrive.

When the eighth bit has been sampled, the block clears the start bit and raises a one-cycle completion request. The serial output keeps the last bit it sent.

Top module: `lnk_shift_port`

## Requirements
- R1: After reset, `data_q` is 0x00, `ctrl_q` is 0x00 (external clock, idle), `sck_o` is 1, `sck_oe` is 0, `sd_o` is 1 and `irq` is 0.
- R2: A write to the control register (`wr_sel`=1) while idle stores bit 0 as the clock source (1 = internal, 0 = external) and starts a transfer if bit 7 is 1. `ctrl_q` reads {busy, 6'b0, source}, so bit 7 reads 1 for the whole transfer and 0 again once it completes.
- R3: The written byte leaves on `sd_o` most significant bit first. `sd_o` changes only on a falling shift-clock edge.
- R4: On each rising shift-clock edge the register shifts left and takes `sd_i` into bit 0. After eight rising edges `data_q` holds the bits received, first bit in bit 7.
- R5: With the internal source, `sck_oe` is 1 and `sck_o` rests high. During a transfer `sck_o` goes low exactly eight times, and each low phase and each high phase lasts HALF_DIV system clocks.
- R6: `irq` is a pulse of one cycle, issued once per transfer in the cycle where `ctrl_q` bit 7 returns to 0.
- R7: With the external source, a started transfer stays busy for any length of time until eight rising edges of `sck_i` have been seen. Then it completes.
- R8: After a transfer, `sd_o` keeps the last bit sent until the next transfer.
- R9: With the internal source and `sd_i` held high (no partner), the received byte is 0xFF.
- R10: Writes to the data register (`wr_sel`=0) or to the control register while a transfer is active change nothing.
- R11: Toggling `sck_i` while idle, or while the internal source is selected, does not change `data_q`, `ctrl_q` or `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = data register, 1 = control register |
| wr_data | input | DATA_W | Write data; the control register uses bits 7 and 0 |
| data_q | output | DATA_W | Data register contents |
| ctrl_q | output | 8 | Control read-back: bit 7 busy, bit 0 clock source |
| sck_i | input | 1 | External shift clock pin |
| sck_o | output | 1 | Internally generated shift clock |
| sck_oe | output | 1 | Drive enable for the clock pin (internal source) |
| sd_i | input | 1 | Serial data in |
| sd_o | output | 1 | Serial data out |
| irq | output | 1 | Transfer-complete pulse |

## Verification
A wrong bit counter shows up within one byte time, either as a fall count on `sck_o` other than eight or as a completion pulse at the wrong moment. A bad shift direction, or sampling on the wrong edge, shows up in the byte seen on `sd_o` and in the byte left in `data_q` at completion. The bench therefore sweeps every byte value in master role, each against a computed partner byte. A busy flag that drops on its own in slave role is caught during a long stall with no clock edges. A busy guard that leaks is caught when the data register changes, read straight after the transfer that carried the stray write.

// File: rtl/lnk_pkg.sv
package lnk_pkg;

   typedef enum logic {
      LNK_CLK_EXT = 1'b0,
      LNK_CLK_INT = 1'b1
   } lnk_clk_e;

   typedef enum logic {
      LNK_SEL_DATA = 1'b0,
      LNK_SEL_CTRL = 1'b1
   } lnk_sel_e;

   localparam int unsigned LNK_CTRL_W   = 8;
   localparam int unsigned LNK_START_B  = 7;
   localparam int unsigned LNK_SRC_B    = 0;

   function automatic logic [LNK_CTRL_W-1:0] lnk_ctrl_image(input logic busy,
                                                           input lnk_clk_e src);
      logic [LNK_CTRL_W-1:0] img;
      img              = '0;
      img[LNK_START_B] = busy;
      img[LNK_SRC_B]   = src;
      return img;
   endfunction

endpackage

// File: rtl/lnk_edge_sync.sv
module lnk_edge_sync #(
   parameter int unsigned STAGES   = 2,
   parameter logic        IDLE_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic level_o,
   output logic rise_o,
   output logic fall_o
);
   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("lnk_edge_sync: STAGES must be at least 2");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q[0] <= IDLE_VAL;
            else        chain_q[0] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q[s] <= IDLE_VAL;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= IDLE_VAL;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign level_o = chain_q[STAGES-1];
   assign rise_o  = level_o & ~prev_q;
   assign fall_o  = ~level_o & prev_q;

endmodule

// File: rtl/lnk_tick_gen.sv
module lnk_tick_gen #(
   parameter int unsigned HALF_DIV = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic sck_o,
   output logic fall_o,
   output logic rise_o
);
   localparam int unsigned CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             sck_q;
   logic             wrap;

   if (HALF_DIV < 4) begin : g_bad_div
      $error("lnk_tick_gen: HALF_DIV must be at least 4");
   end

   assign wrap   = run_i && (cnt_q == CNT_LAST);
   assign fall_o = wrap && sck_q;
   assign rise_o = wrap && !sck_q;
   assign sck_o  = sck_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         sck_q <= 1'b1;
      end else if (!run_i) begin
         cnt_q <= '0;
         sck_q <= 1'b1;
      end else if (wrap) begin
         cnt_q <= '0;
         sck_q <= ~sck_q;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/lnk_shift_core.sv
module lnk_shift_core #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [DATA_W-1:0] load_data_i,
   input  logic              start_i,
   input  logic              fall_i,
   input  logic              rise_i,
   input  logic              sd_i,
   output logic              busy_o,
   output logic [DATA_W-1:0] data_o,
   output logic              sd_o,
   output logic              done_o
);
   localparam int unsigned BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

   logic [DATA_W-1:0] sr_q;
   logic [BIT_W-1:0]  bit_q;
   logic              busy_q;
   logic              sd_q;
   logic              done_q;

   if (DATA_W < 2) begin : g_bad_width
      $error("lnk_shift_core: DATA_W must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sr_q   <= '0;
         bit_q  <= '0;
         busy_q <= 1'b0;
         sd_q   <= 1'b1;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (load_i) sr_q <= load_data_i;
            if (start_i) begin
               busy_q <= 1'b1;
               bit_q  <= '0;
            end
         end else begin
            if (fall_i) sd_q <= sr_q[DATA_W-1];
            if (rise_i) begin
               sr_q  <= {sr_q[DATA_W-2:0], sd_i};
               bit_q <= bit_q + 1'b1;
               if (bit_q == BIT_LAST) begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
               end
            end
         end
      end
   end

   assign busy_o = busy_q;
   assign data_o = sr_q;
   assign sd_o   = sd_q;
   assign done_o = done_q;

endmodule

// File: rtl/lnk_shift_port.sv
module lnk_shift_port
   import lnk_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned HALF_DIV    = 256,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic                  wr_sel,
   input  logic [DATA_W-1:0]     wr_data,
   output logic [DATA_W-1:0]     data_q,
   output logic [LNK_CTRL_W-1:0] ctrl_q,
   input  logic                  sck_i,
   output logic                  sck_o,
   output logic                  sck_oe,
   input  logic                  sd_i,
   output logic                  sd_o,
   output logic                  irq
);
   if (DATA_W < LNK_CTRL_W) begin : g_bad_bus
      $error("lnk_shift_port: DATA_W must cover the control byte");
   end

   lnk_clk_e src_q;
   logic     busy;
   logic     ctrl_wr, data_wr, start;
   logic     int_fall, int_rise;
   logic     ext_fall, ext_rise, ext_lvl;
   logic     sd_sync, sd_rise_unused, sd_fall_unused;
   logic     sh_fall, sh_rise;

   assign ctrl_wr = wr_en && (wr_sel == LNK_SEL_CTRL) && !busy;
   assign data_wr = wr_en && (wr_sel == LNK_SEL_DATA) && !busy;
   assign start   = ctrl_wr && wr_data[LNK_START_B];

   always_ff @(posedge clk) begin
      if (!rst_n)       src_q <= LNK_CLK_EXT;
      else if (ctrl_wr) src_q <= lnk_clk_e'(wr_data[LNK_SRC_B]);
   end

   lnk_tick_gen #(
      .HALF_DIV (HALF_DIV)
   ) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (busy && (src_q == LNK_CLK_INT)),
      .sck_o  (sck_o),
      .fall_o (int_fall),
      .rise_o (int_rise)
   );

   lnk_edge_sync #(
      .STAGES   (SYNC_STAGES),
      .IDLE_VAL (1'b1)
   ) u_sck_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (sck_i),
      .level_o (ext_lvl),
      .rise_o  (ext_rise),
      .fall_o  (ext_fall)
   );

   lnk_edge_sync #(
      .STAGES   (SYNC_STAGES),
      .IDLE_VAL (1'b1)
   ) u_sd_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (sd_i),
      .level_o (sd_sync),
      .rise_o  (sd_rise_unused),
      .fall_o  (sd_fall_unused)
   );

   always_comb begin
      if (src_q == LNK_CLK_INT) begin
         sh_fall = int_fall;
         sh_rise = int_rise;
      end else begin
         sh_fall = ext_fall;
         sh_rise = ext_rise;
      end
   end

   lnk_shift_core #(
      .DATA_W (DATA_W)
   ) u_core (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (data_wr),
      .load_data_i (wr_data),
      .start_i     (start),
      .fall_i      (sh_fall),
      .rise_i      (sh_rise),
      .sd_i        (sd_sync),
      .busy_o      (busy),
      .data_o      (data_q),
      .sd_o        (sd_o),
      .done_o      (irq)
   );

   assign ctrl_q = lnk_ctrl_image(busy, src_q);
   assign sck_oe = (src_q == LNK_CLK_INT);

   logic unused_ok;
   assign unused_ok = &{1'b0, ext_lvl, sd_rise_unused, sd_fall_unused};

endmodule

// File: rtl/lnk_shift_port_chk.sv
module lnk_shift_port_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [DATA_W-1:0] data_q,
   input logic [7:0]        ctrl_q,
   input logic              sck_o,
   input logic              sd_o,
   input logic              irq
);
   // R5
   idle_clk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[7] |-> sck_o);

   // R6
   irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   // R6
   irq_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (!ctrl_q[7] && $past(ctrl_q[7])));

   // R8
   sd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q[7] && !wr_en) |=> $stable(sd_o));

   // R11
   idle_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q[7] && !wr_en) |=> $stable(data_q));

endmodule

bind lnk_shift_port lnk_shift_port_chk #(.DATA_W(DATA_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .wr_en  (wr_en),
   .data_q (data_q),
   .ctrl_q (ctrl_q),
   .sck_o  (sck_o),
   .sd_o   (sd_o),
   .irq    (irq)
);

// File: tb/lnk_shift_port_bench.sv
module lnk_shift_port_bench;
   localparam int HD = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_sel = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] data_q, ctrl_q;
   logic       sck_i = 1'b1;
   logic       sck_o, sck_oe, sd_o, irq;
   logic       sd_task = 1'b1;
   logic       sd_prt = 1'b1;
   logic       prt_en = 1'b0;
   logic       sd_i;

   int nerr = 0;
   int ntot = 0;

   // monitor state
   logic       prev_sck = 1'b1;
   logic       prev_sdo = 1'b1;
   logic       int_mode = 1'b0;
   logic [7:0] partner = 8'hFF;
   int         p_idx = 0;
   int         fall_cnt = 0;
   int         irq_cnt = 0;
   int         lo_len = 0;
   logic       lo_bad = 1'b0;
   logic       sdo_bad = 1'b0;
   logic [7:0] tx_cap = '0;

   assign sd_i = prt_en ? sd_prt : sd_task;

   always #4 clk = ~clk;

   lnk_shift_port #(.DATA_W(8), .HALF_DIV(HD), .SYNC_STAGES(2)) u_lnk_shift_port (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .data_q(data_q), .ctrl_q(ctrl_q), .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
      .sd_i(sd_i), .sd_o(sd_o), .irq(irq)
   );

   always @(negedge clk) begin
      if (irq) irq_cnt++;
      if (prev_sck && !sck_o) begin
         fall_cnt++;
         if (prt_en && p_idx < 8) begin
            sd_prt = partner[7 - p_idx];
            p_idx++;
         end
      end
      if (!sck_o) lo_len++;
      if (!prev_sck && sck_o) begin
         tx_cap = {tx_cap[6:0], sd_o};
         if (lo_len != HD) lo_bad = 1'b1;
         lo_len = 0;
      end
      if (int_mode && (sd_o != prev_sdo) && !(prev_sck && !sck_o)) sdo_bad = 1'b1;
      prev_sck = sck_o;
      prev_sdo = sd_o;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      ntot++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic sel, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic clear_mon();
      fall_cnt = 0; irq_cnt = 0; lo_len = 0; lo_bad = 1'b0;
      sdo_bad = 1'b0; tx_cap = '0; p_idx = 0;
   endtask

   task automatic wait_idle(input string tag);
      int n = 0;
      while (ctrl_q[7] && n < 2000) begin
         @(negedge clk);
         n++;
      end
      chk(tag, {31'd0, ctrl_q[7]}, 32'd0);
   endtask

   task automatic int_xfer(input logic [7:0] tx, input logic [7:0] prt, input logic poke);
      partner = prt; prt_en = 1'b1; int_mode = 1'b1;
      clear_mon();
      wr(1'b0, tx);
      wr(1'b1, 8'h81);
      chk("R2 busy readback", ctrl_q, 8'h81);
      if (poke) begin
         repeat (3) @(negedge clk);
         wr(1'b0, ~prt);
         wr(1'b1, 8'h00);
         chk("R10 ctrl write ignored", ctrl_q, 8'h81);
      end
      wait_idle("R2 start bit clears");
      @(negedge clk);
      chk("R4 received byte", data_q, prt);
      chk("R3 msb-first tx", tx_cap, tx);
      chk("R5 eight low pulses", fall_cnt, 8);
      chk("R5 phase length", {31'd0, lo_bad}, 0);
      chk("R3 sd_o on falling edge", {31'd0, sdo_bad}, 0);
      chk("R6 one irq", irq_cnt, 1);
      chk("R2 ctrl after end", ctrl_q, 8'h01);
      chk("R5 clock idles high", {31'd0, sck_o}, 1);
      int_mode = 1'b0;
   endtask

   task automatic ext_bits(input logic [7:0] tx, input logic [7:0] rx, input int from, input int upto,
                           inout logic [7:0] cap);
      for (int i = from; i < upto; i++) begin
         sck_i = 1'b0;
         sd_task = rx[7 - i];
         repeat (8) @(negedge clk);
         cap = {cap[6:0], sd_o};
         sck_i = 1'b1;
         repeat (8) @(negedge clk);
      end
   endtask

   task automatic ext_xfer(input logic [7:0] tx, input logic [7:0] rx, input logic stall);
      logic [7:0] cap = '0;
      prt_en = 1'b0;
      clear_mon();
      wr(1'b0, tx);
      wr(1'b1, 8'h80);
      chk("R2 ext busy readback", ctrl_q, 8'h80);
      chk("R5 no drive in slave role", {31'd0, sck_oe}, 0);
      if (stall) begin
         ext_bits(tx, rx, 0, 5, cap);
         repeat (2000) @(negedge clk);
         chk("R7 still waiting", {31'd0, ctrl_q[7]}, 1);
         chk("R7 no early irq", irq_cnt, 0);
         wr(1'b0, 8'h3C);
         wr(1'b1, 8'h81);
         chk("R10 ctrl write ignored ext", ctrl_q, 8'h80);
         ext_bits(tx, rx, 5, 8, cap);
      end else begin
         ext_bits(tx, rx, 0, 8, cap);
      end
      repeat (4) @(negedge clk);
      chk("R7 completes after eight", {31'd0, ctrl_q[7]}, 0);
      chk("R4 ext received byte", data_q, rx);
      chk("R3 ext msb-first tx", cap, tx);
      chk("R6 ext one irq", irq_cnt, 1);
      chk("R8 holds last bit", {31'd0, sd_o}, {31'd0, tx[0]});
      repeat (40) @(negedge clk);
      chk("R8 still holds", {31'd0, sd_o}, {31'd0, tx[0]});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, ntot);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset values
      chk("R1 data", data_q, 8'h00);
      chk("R1 ctrl", ctrl_q, 8'h00);
      chk("R1 sck_o", {31'd0, sck_o}, 1);
      chk("R1 sck_oe", {31'd0, sck_oe}, 0);
      chk("R1 sd_o", {31'd0, sd_o}, 1);
      chk("R1 irq", {31'd0, irq}, 0);

      // R11 external edges while idle
      wr(1'b0, 8'h5A);
      clear_mon();
      for (int k = 0; k < 10; k++) begin
         sck_i = ~sck_i;
         repeat (6) @(negedge clk);
      end
      sck_i = 1'b1;
      repeat (6) @(negedge clk);
      chk("R11 data idle", data_q, 8'h5A);
      chk("R11 ctrl idle", ctrl_q, 8'h00);
      chk("R11 no irq", irq_cnt, 0);

      // R9 no partner
      int_xfer(8'hC3, 8'hFF, 1'b0);
      chk("R9 all ones", data_q, 8'hFF);
      chk("R8 internal last bit", {31'd0, sd_o}, 1);
      chk("R5 drive in master role", {31'd0, sck_oe}, 1);

      // R10 write during internal transfer
      int_xfer(8'h96, 8'h4B, 1'b1);

      // R11 external edges ignored in internal mode
      for (int k = 0; k < 6; k++) begin
         sck_i = ~sck_i;
         repeat (6) @(negedge clk);
      end
      sck_i = 1'b1;
      repeat (6) @(negedge clk);
      chk("R11 internal mode data", data_q, 8'h4B);

      // full sweep, master role (R3 R4 R5 R6)
      for (int v = 0; v < 256; v++) begin
         int_xfer(8'(v), 8'((v * 37 + 11) % 256), 1'b0);
      end

      // slave role (R7 R8 R10)
      ext_xfer(8'hA5, 8'h3C, 1'b0);
      ext_xfer(8'h01, 8'hE7, 1'b1);
      chk("R10 data write ignored ext", data_q, 8'hE7);
      ext_xfer(8'h7E, 8'h81, 1'b0);

      $display("Result: errors=%0d of %0d checks", nerr, ntot);
      $finish;
   end

endmodule